// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block holds the floating-point register state of a processor core: thirty-two 64-bit double registers with the even names f0, f2, up to f62. It has two combinational read ports and one clocked write port. Each port takes the 5-bit register field straight from an instruction, plus a precision select that chooses between single and double.

The field is decoded in one of two ways, depending on the precision. A double access rotates the field. The field's lowest bit becomes the top bit of the 6-bit register number. Field bits 4:1 become number bits 4:1, and number bit 0 is always zero. A field of 1 therefore reaches f32, and a field of 5 reaches f36.

A single access uses the field unchanged to name f0 to f31. These single names overlap halves of the lower sixteen doubles: the even name is the upper half and the odd name is the lower half. Single reads return their 32 bits in the low half of the data bus. Single writes take the low 32 bits of the write data and change only their own half of the double.

Top module: `fprf_top`

## Requirements
- R1: An active-high synchronous reset clears every double register, so every read after it returns zero.
- R2: With the precision select at 1 (double), register field F selects double register number {F[0], F[4:1], 0}. Field 1 is f32, field 5 is f36, field 31 is f62 and field 30 is f30.
- R3: With the precision select at 0 (single), field S reads single register S. This is bits 63:32 of double f(S with bit 0 cleared) when S is even, and bits 31:0 when S is odd. The value is returned on data bits 31:0, and data bits 63:32 read as zero.
- R4: A single write stores write-data bits 31:0 into its own half of the aliased double and leaves the other half unchanged.
- R5: No single-precision access ever reads or changes doubles f32 to f62.
- R6: A double write stores all 64 bits. A double read of the same field after the write edge returns that value.
- R7: Writes take effect on the rising clock edge. A read of the register being written in the same cycle returns the value held before the write.
- R8: The two read ports decode and read independently. With equal field and precision they return equal data.
- R9: With the write enable low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd0_field | input | 5 | Register field, read port 0 |
| rd0_dbl | input | 1 | Precision of read port 0 (1 = double, 0 = single) |
| rd0_data | output | 64 | Read data, port 0 |
| rd1_field | input | 5 | Register field, read port 1 |
| rd1_dbl | input | 1 | Precision of read port 1 (1 = double, 0 = single) |
| rd1_data | output | 64 | Read data, port 1 |
| wr_en | input | 1 | Write enable |
| wr_field | input | 5 | Register field, write port |
| wr_dbl | input | 1 | Precision of write port (1 = double, 0 = single) |
| wr_data | input | 64 | Write data; single writes use bits 31:0 |

## Verification
The assertions assume that every input is at a known value at each rising edge while reset is low. They also assume reset is held for at least one edge before the first check. The write-visibility and half-preservation properties also assume that a double read which names the entry just written keeps that field across the edge. The bench drives every input from known values at the falling edge, holds reset over two edges at the start, and in the middle of the run, and reads the written entry back on port 0 in the following step.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int NUM_DBL = 32;
    localparam int DW      = 64;
    localparam int FW      = 5;
    localparam int HALF_W  = DW / 2;
    localparam int IDX_W   = $clog2(NUM_DBL);
    localparam int NUM_RD  = 2;

    typedef enum logic {
        PREC_SGL = 1'b0,
        PREC_DBL = 1'b1
    } prec_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        prec_e            prec;
        logic             half_lo;
    } fprf_sel_t;

    typedef logic [NUM_DBL-1:0][DW-1:0] fprf_bank_t;

    // Double: the field's lowest bit carries the high bit of the register number.
    function automatic logic [IDX_W-1:0] dbl_index(input logic [FW-1:0] field);
        return {field[0], field[FW-1:1]};
    endfunction

    // Single: the name's upper bits pick one of the lower doubles.
    function automatic logic [IDX_W-1:0] sgl_index(input logic [FW-1:0] field);
        return {1'b0, field[FW-1:1]};
    endfunction

endpackage

// File: rtl/fprf_decode.sv
module fprf_decode
    import fprf_pkg::*;
(
    input  logic [FW-1:0] field,
    input  logic          dbl,
    output fprf_sel_t     sel
);
    always_comb begin
        if (dbl) begin
            sel.idx     = dbl_index(field);
            sel.prec    = PREC_DBL;
            sel.half_lo = 1'b0;
        end else begin
            sel.idx     = sgl_index(field);
            sel.prec    = PREC_SGL;
            sel.half_lo = field[0];
        end
    end
endmodule

// File: rtl/fprf_store.sv
module fprf_store
    import fprf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  fprf_sel_t  sel,
    input  logic [DW-1:0] wdata,
    output fprf_bank_t bank
);
    for (genvar gi = 0; gi < NUM_DBL; gi++) begin : g_entry
        logic hit;
        assign hit = we && (sel.idx == IDX_W'(gi));

        always_ff @(posedge clk) begin
            if (rst) begin
                bank[gi] <= '0;
            end else if (hit) begin
                if (sel.prec == PREC_DBL) begin
                    bank[gi] <= wdata;
                end else if (sel.half_lo) begin
                    bank[gi][HALF_W-1:0] <= wdata[HALF_W-1:0];
                end else begin
                    bank[gi][DW-1:HALF_W] <= wdata[HALF_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/fprf_rmux.sv
module fprf_rmux
    import fprf_pkg::*;
(
    input  fprf_bank_t    bank,
    input  fprf_sel_t     sel,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0]     word;
    logic [HALF_W-1:0] part;

    always_comb begin
        word = bank[sel.idx];
        part = sel.half_lo ? word[HALF_W-1:0] : word[DW-1:HALF_W];
        if (sel.prec == PREC_DBL) begin
            rdata = word;
        end else begin
            rdata = {{HALF_W{1'b0}}, part};
        end
    end
endmodule

// File: rtl/fprf_top.sv
module fprf_top
    import fprf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    rd0_field,
    input  logic          rd0_dbl,
    output logic [63:0]   rd0_data,
    input  logic [4:0]    rd1_field,
    input  logic          rd1_dbl,
    output logic [63:0]   rd1_data,
    input  logic          wr_en,
    input  logic [4:0]    wr_field,
    input  logic          wr_dbl,
    input  logic [63:0]   wr_data
);
    fprf_bank_t bank;
    fprf_sel_t  wsel;

    logic [NUM_RD-1:0][FW-1:0] rfield;
    logic [NUM_RD-1:0]         rdbl;
    logic [NUM_RD-1:0][DW-1:0] rdata;

    assign rfield = {rd1_field, rd0_field};
    assign rdbl   = {rd1_dbl, rd0_dbl};
    assign rd0_data = rdata[0];
    assign rd1_data = rdata[1];

    fprf_decode u_wdec (
        .field (wr_field),
        .dbl   (wr_dbl),
        .sel   (wsel)
    );

    fprf_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .sel   (wsel),
        .wdata (wr_data),
        .bank  (bank)
    );

    for (genvar gp = 0; gp < NUM_RD; gp++) begin : g_rport
        fprf_sel_t rsel;

        fprf_decode u_rdec (
            .field (rfield[gp]),
            .dbl   (rdbl[gp]),
            .sel   (rsel)
        );

        fprf_rmux u_rmux (
            .bank  (bank),
            .sel   (rsel),
            .rdata (rdata[gp])
        );
    end
endmodule

// File: rtl/fprf_chk.sv
module fprf_chk (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  rd0_field,
    input logic        rd0_dbl,
    input logic [63:0] rd0_data,
    input logic [4:0]  rd1_field,
    input logic        rd1_dbl,
    input logic [63:0] rd1_data,
    input logic        wr_en,
    input logic [4:0]  wr_field,
    input logic        wr_dbl,
    input logic [63:0] wr_data
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd0_data == 64'd0 && rd1_data == 64'd0)); // R1

    AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!rd0_dbl) |-> (rd0_data[63:32] == 32'd0)); // R3

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (rd0_field == rd1_field && rd0_dbl == rd1_dbl) |-> (rd0_data == rd1_data)); // R8

    AST_DBL_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && wr_dbl) && rd0_dbl && rd0_field == $past(wr_field))
        |-> (rd0_data == $past(wr_data))); // R6

    AST_SGL_HALF_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && !wr_dbl) && rd0_dbl
         && rd0_field == {$past(wr_field[4:1]), 1'b0})
        |-> ($past(wr_field[0]) ? (rd0_data[31:0] == $past(wr_data[31:0]))
                                : (rd0_data[63:32] == $past(wr_data[31:0])))); // R4

    AST_SGL_HALF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && !wr_dbl) && rd0_dbl && $stable(rd0_field) && $past(rd0_dbl)
         && rd0_field == {$past(wr_field[4:1]), 1'b0})
        |-> ($past(wr_field[0]) ? (rd0_data[63:32] == $past(rd0_data[63:32]))
                                : (rd0_data[31:0] == $past(rd0_data[31:0])))); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $stable(rd0_field) && $stable(rd0_dbl))
        |-> $stable(rd0_data)); // R9

    AST_SGL_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && !wr_dbl) && rd0_dbl && rd0_field[0]
         && $stable(rd0_field) && $past(rd0_dbl))
        |-> $stable(rd0_data)); // R5
endmodule

bind fprf_top fprf_chk u_chk (.*);

// File: tb/sim_fprf_top.sv
`timescale 1ns/1ps
module sim_fprf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd0_field, rd1_field, wr_field;
    logic        rd0_dbl, rd1_dbl, wr_dbl, wr_en;
    logic [63:0] rd0_data, rd1_data, wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fprf_top u0 (.*);

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic        wd;
        logic [4:0]  wf;
        logic [63:0] wdat;
        logic        rdb;
        logic [4:0]  rf;
        logic [63:0] exp;
    } vec_t;

    // Read is sampled before the row's write edge.
    localparam vec_t VEC [18] = '{
        '{4'd7, 1'b1, 1'b1, 5'd1,  64'h1111_2222_3333_4444, 1'b1, 5'd1,  64'h0},                     // R7
        '{4'd2, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd1,  64'h1111_2222_3333_4444},   // R2 f32
        '{4'd6, 1'b1, 1'b1, 5'd5,  64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 5'd0,  64'h0},                     // R6
        '{4'd2, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd5,  64'hAAAA_BBBB_CCCC_DDDD},   // R2 f36
        '{4'd6, 1'b1, 1'b1, 5'd2,  64'h0123_4567_89AB_CDEF, 1'b1, 5'd1,  64'h1111_2222_3333_4444},   // R6
        '{4'd7, 1'b1, 1'b0, 5'd2,  64'hFFFF_FFFF_DEAD_BEEF, 1'b1, 5'd2,  64'h0123_4567_89AB_CDEF},   // R7
        '{4'd4, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd2,  64'hDEAD_BEEF_89AB_CDEF},   // R4
        '{4'd3, 1'b1, 1'b0, 5'd3,  64'h0000_0000_CAFE_F00D, 1'b0, 5'd3,  64'h0000_0000_89AB_CDEF},   // R3
        '{4'd4, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd2,  64'hDEAD_BEEF_CAFE_F00D},   // R4
        '{4'd3, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd2,  64'h0000_0000_DEAD_BEEF},   // R3
        '{4'd9, 1'b0, 1'b1, 5'd2,  64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 5'd2,  64'hDEAD_BEEF_CAFE_F00D},   // R9
        '{4'd9, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd2,  64'hDEAD_BEEF_CAFE_F00D},   // R9
        '{4'd5, 1'b1, 1'b0, 5'd31, 64'h0000_0000_5555_AAAA, 1'b1, 5'd1,  64'h1111_2222_3333_4444},   // R5
        '{4'd5, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd1,  64'h1111_2222_3333_4444},   // R5
        '{4'd2, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd30, 64'h0000_0000_5555_AAAA},   // R2 f30
        '{4'd6, 1'b1, 1'b1, 5'd31, 64'hFEDC_BA98_7654_3210, 1'b1, 5'd30, 64'h0000_0000_5555_AAAA},   // R6
        '{4'd2, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd31, 64'hFEDC_BA98_7654_3210},   // R2 f62
        '{4'd3, 1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd30, 64'h0}                      // R3
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic wd, input logic [4:0] wf, input logic [63:0] wdat,
                         input logic r0d, input logic [4:0] r0f, input logic r1d, input logic [4:0] r1f);
        @(negedge clk);
        wr_en = we; wr_dbl = wd; wr_field = wf; wr_data = wdat;
        rd0_dbl = r0d; rd0_field = r0f; rd1_dbl = r1d; rd1_field = r1f;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        wr_en = 1'b0; wr_dbl = 1'b0; wr_field = '0; wr_data = '0;
        rd0_field = '0; rd0_dbl = 1'b1; rd1_field = '0; rd1_dbl = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state on both ports
        drive(1'b0, 1'b0, 5'd0, 64'h0, 1'b1, 5'd31, 1'b0, 5'd17);
        check("R1 rd0 f62", rd0_data, 64'h0);
        check("R1 rd1 s17", rd1_data, 64'h0);

        for (int i = 0; i < 18; i++) begin
            drive(VEC[i].we, VEC[i].wd, VEC[i].wf, VEC[i].wdat, VEC[i].rdb, VEC[i].rf, 1'b1, 5'd0);
            n_cmp++;
            if (rd0_data !== VEC[i].exp) begin
                n_bad++;
                $display("FAIL R%0d row %0d actual=%h expected=%h", VEC[i].req, i, rd0_data, VEC[i].exp);
            end
        end

        // R8: independent ports, different selections at once
        drive(1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 5'd31, 1'b1, 5'd31);
        check("R8 rd0 s31", rd0_data, 64'h0000_0000_5555_AAAA);
        check("R8 rd1 f62", rd1_data, 64'hFEDC_BA98_7654_3210);
        drive(1'b0, 1'b0, 5'd0, 64'h0, 1'b1, 5'd5, 1'b1, 5'd5);
        check("R8 same sel", rd1_data, rd0_data);
        check("R8 rd1 f36", rd1_data, 64'hAAAA_BBBB_CCCC_DDDD);

        // R5: single write to name 1 leaves f32 (field 1) alone
        drive(1'b1, 1'b0, 5'd1, 64'h0000_0000_7777_7777, 1'b1, 5'd1, 1'b1, 5'd0);
        drive(1'b0, 1'b0, 5'd0, 64'h0, 1'b1, 5'd1, 1'b1, 5'd0);
        check("R5 f32 kept", rd0_data, 64'h1111_2222_3333_4444);
        check("R4 f0 lower", rd1_data, 64'h0000_0000_7777_7777);

        // R1: mid-run reset clears written registers
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        drive(1'b0, 1'b0, 5'd0, 64'h0, 1'b1, 5'd5, 1'b1, 5'd2);
        check("R1 f36 cleared", rd0_data, 64'h0);
        check("R1 f2 cleared", rd1_data, 64'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule